// File: doc/BRIEF.md
# Extended Region Decoder

This block sorts a 64-bit virtual address into one of five regions: extended user space, extended supervisor space, the direct physical window, extended kernel-mapped space, and the sign-extended 32-bit compatibility range. It checks the requesting privilege and the three status enable bits (kernel, supervisor, user) against the rules of the region it finds. The result is a kind code and, where one applies, a physical address.

In the direct physical window the block chooses an access mode for each 2^59-byte slice. Slices enabled in an 8-bit mask take an alternate mode, and all other slices use mode 0. The mode decides which status enable bit must be set. Together with the privilege it also decides whether the access faults, goes to the TLB, or passes straight through with the address cut down by the physical address mask. Compatibility addresses are handed on unchanged to a separate 32-bit segment translator. The TLB and that translator are outside this block.

A request is accepted in any cycle where `req_valid` is high, and its result appears registered on the next cycle.

Top module: `ext_region_decoder`

## Requirements
- R1: Each cycle with `req_valid` high yields `res_valid` high in the following cycle. A cycle with `req_valid` low yields `res_valid` low in the following cycle. After reset `res_valid`, `res_kind` and `res_paddr` are all 0.
- R2: An address no greater than 0x7FFFFFFF, or no less than 0xFFFFFFFF80000000, gives kind COMPAT (3) with `res_paddr` equal to the address. This applies whatever the privilege or status bits are.
- R3: Any other address below 0x4000000000000000 gives kind TLB (1) when `st_ux` is set and the address is at most 0x3FFFFFFFFFFFFFFF & `seg_mask`. Otherwise it gives kind ERROR (2). The privilege is not checked.
- R4: An address from 0x4000000000000000 to 0x7FFFFFFFFFFFFFFF gives TLB only when all three hold: the privilege is kernel (0 or 3) or supervisor (1), `st_sx` is set, and the address is at most 0x7FFFFFFFFFFFFFFF & `seg_mask`. Otherwise it gives ERROR.
- R5: An address from 0x8000000000000000 to 0xBFFFFFFFFFFFFFFF gives ERROR when its bits 58:0 exceed `pa_mask`.
- R6: In the physical window the access mode is `win_alt_mode` when bit `addr[61:59]` of `win_slice_en` is set, and 0 otherwise.
- R7: In the physical window the access is an ERROR if the status bit its mode needs is clear. Modes 0, 1 and 6 need `st_kx`. Modes 2 and 5 need `st_sx`. Modes 3, 4 and 7 need `st_ux`.
- R8: In the physical window the privilege selects the outcome as follows. Kernel privilege gives TLB for modes 1 to 3 and DIRECT (0) for all other modes. Supervisor privilege gives ERROR for modes 0 and 1, TLB for modes 2 to 4, and DIRECT for modes 5 to 7. User privilege (2) gives ERROR for modes 0, 1, 2 and 5, TLB for modes 3 and 4, and DIRECT for modes 6 and 7.
- R9: A DIRECT result carries `res_paddr` equal to the address ANDed with `pa_mask`.
- R10: An address from 0xC000000000000000 to 0xFFFFFFFF7FFFFFFF gives TLB only when all three hold: the privilege is kernel, `st_kx` is set, and the address is at most 0xFFFFFFFF7FFFFFFF & `seg_mask`. Otherwise it gives ERROR.
- R11: Every TLB or ERROR result carries `res_paddr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 64 | Virtual address to classify |
| req_priv | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user, 3 kernel at error level |
| st_kx | input | 1 | Kernel extended-address enable |
| st_sx | input | 1 | Supervisor extended-address enable |
| st_ux | input | 1 | User extended-address enable |
| win_slice_en | input | 8 | Per-slice alternate-mode enable for the physical window |
| win_alt_mode | input | 3 | Alternate access mode for enabled slices |
| seg_mask | input | 64 | Implemented virtual-segment mask (static) |
| pa_mask | input | 64 | Implemented physical-address mask (static) |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_kind | output | 2 | 0 DIRECT, 1 TLB, 2 ERROR, 3 COMPAT |
| res_paddr | output | 64 | Physical address (DIRECT), address passed on (COMPAT), else 0 |

## Verification
Addresses are placed on both sides of each region edge and each segment-mask limit, so that an off-by-one in range decoding shows up as a wrong kind. In the physical window, one address is tried with the slice enable set on a different slice and then on its own slice. This separates the selection of the alternate mode from its use. Each mode is paired with a privilege and status setting that picks a single cell of the mode table, so swapped gating bits or swapped TLB and DIRECT outcomes give different results. Back-to-back and isolated requests separate the one-cycle result pulse from a held valid.

// File: rtl/ext_region_decoder.sv
module ext_region_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_priv,
  input  logic        st_kx,
  input  logic        st_sx,
  input  logic        st_ux,
  input  logic [7:0]  win_slice_en,
  input  logic [2:0]  win_alt_mode,
  input  logic [63:0] seg_mask,
  input  logic [63:0] pa_mask,
  output logic        res_valid,
  output logic [1:0]  res_kind,
  output logic [63:0] res_paddr
);

  localparam logic [1:0]  K_DIRECT = 2'd0;
  localparam logic [1:0]  K_TLB    = 2'd1;
  localparam logic [1:0]  K_ERROR  = 2'd2;
  localparam logic [1:0]  K_COMPAT = 2'd3;

  localparam logic [63:0] LOW32_TOP  = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] HIGH32_BOT = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] XU_TOP     = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] XS_TOP     = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] XK_TOP     = 64'hFFFF_FFFF_7FFF_FFFF;

  logic        in_compat;
  logic        p_kern, p_sup, p_user;
  logic        xu_ok, xs_ok, xk_ok, win_in_range;
  logic [2:0]  win_mode;
  logic        mode_gate, mode_fault, mode_tlb;
  logic [1:0]  nxt_kind;
  logic [63:0] nxt_paddr;

  assign in_compat = (req_vaddr <= LOW32_TOP) || (req_vaddr >= HIGH32_BOT);

  assign p_sup  = (req_priv == 2'd1);
  assign p_user = (req_priv == 2'd2);
  assign p_kern = !p_sup && !p_user;

  assign xu_ok = st_ux && (req_vaddr <= (XU_TOP & seg_mask));
  assign xs_ok = (p_kern || p_sup) && st_sx && (req_vaddr <= (XS_TOP & seg_mask));
  assign xk_ok = p_kern && st_kx && (req_vaddr <= (XK_TOP & seg_mask));

  assign win_in_range = ({5'b0, req_vaddr[58:0]} <= pa_mask);
  assign win_mode     = win_slice_en[req_vaddr[61:59]] ? win_alt_mode : 3'd0;

  always_comb begin
    case (win_mode)
      3'd0, 3'd1, 3'd6: mode_gate = st_kx;
      3'd2, 3'd5:       mode_gate = st_sx;
      default:          mode_gate = st_ux;
    endcase
  end

  always_comb begin
    if (p_user) begin
      mode_fault = (win_mode <= 3'd2) || (win_mode == 3'd5);
      mode_tlb   = (win_mode == 3'd3) || (win_mode == 3'd4);
    end else if (p_sup) begin
      mode_fault = (win_mode <= 3'd1);
      mode_tlb   = (win_mode >= 3'd2) && (win_mode <= 3'd4);
    end else begin
      mode_fault = 1'b0;
      mode_tlb   = (win_mode >= 3'd1) && (win_mode <= 3'd3);
    end
  end

  always_comb begin
    nxt_kind  = K_ERROR;
    nxt_paddr = '0;
    if (in_compat) begin
      nxt_kind  = K_COMPAT;
      nxt_paddr = req_vaddr;
    end else begin
      case (req_vaddr[63:62])
        2'b00: nxt_kind = xu_ok ? K_TLB : K_ERROR;
        2'b01: nxt_kind = xs_ok ? K_TLB : K_ERROR;
        2'b11: nxt_kind = xk_ok ? K_TLB : K_ERROR;
        default: begin
          if (!win_in_range || !mode_gate || mode_fault) begin
            nxt_kind = K_ERROR;
          end else if (mode_tlb) begin
            nxt_kind = K_TLB;
          end else begin
            nxt_kind  = K_DIRECT;
            nxt_paddr = req_vaddr & pa_mask;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= K_DIRECT;
      res_paddr <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_kind  <= nxt_kind;
        res_paddr <= nxt_paddr;
      end
    end
  end

endmodule

// File: rtl/ext_region_decoder_chk.sv
module ext_region_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] req_vaddr,
  input logic [1:0]  req_priv,
  input logic        st_ux,
  input logic [63:0] pa_mask,
  input logic        res_valid,
  input logic [1:0]  res_kind,
  input logic [63:0] res_paddr
);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R1

  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid); // R1

  AST_XUSER_NEEDS_UX: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[63:62] == 2'b00 && req_vaddr > 64'h7FFF_FFFF && !st_ux)
    |=> (res_kind == 2'd2)); // R3

  AST_XKERN_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[63:62] == 2'b11 && req_vaddr < 64'hFFFF_FFFF_8000_0000 && req_priv == 2'd2)
    |=> (res_kind == 2'd2)); // R10

  AST_DIRECT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd0) |-> ((res_paddr & ~pa_mask) == 64'd0)); // R9

  AST_NO_ADDR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_kind == 2'd1 || res_kind == 2'd2)) |-> (res_paddr == 64'd0)); // R11

endmodule

bind ext_region_decoder ext_region_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_priv(req_priv), .st_ux(st_ux), .pa_mask(pa_mask),
  .res_valid(res_valid), .res_kind(res_kind), .res_paddr(res_paddr)
);

// File: tb/ext_region_decoder_bench.sv
module ext_region_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_priv = 2'd0;
  logic        st_kx = 1'b0, st_sx = 1'b0, st_ux = 1'b0;
  logic [7:0]  win_slice_en = '0;
  logic [2:0]  win_alt_mode = '0;
  logic [63:0] seg_mask = 64'hC000_00FF_FFFF_FFFF;
  logic [63:0] pa_mask  = 64'h0000_000F_FFFF_FFFF;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [63:0] res_paddr;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [1:0] DIR = 2'd0, TLB = 2'd1, ERR = 2'd2, CMP = 2'd3;

  always #10 clk = ~clk;

  ext_region_decoder u_ext_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_priv(req_priv), .st_kx(st_kx), .st_sx(st_sx), .st_ux(st_ux),
    .win_slice_en(win_slice_en), .win_alt_mode(win_alt_mode),
    .seg_mask(seg_mask), .pa_mask(pa_mask),
    .res_valid(res_valid), .res_kind(res_kind), .res_paddr(res_paddr)
  );

  task automatic chk(input string tag, input logic [1:0] k, input logic [63:0] p);
    n_run++;
    if (res_valid !== 1'b1 || res_kind !== k || res_paddr !== p) begin
      n_fail++;
      $display("FAIL %s: got v=%b kind=%0d pa=%h, want v=1 kind=%0d pa=%h",
               tag, res_valid, res_kind, res_paddr, k, p);
    end
  endtask

  task automatic ask(input logic [63:0] va, input logic [1:0] pr,
                     input logic kx, input logic sx, input logic ux,
                     input string tag, input logic [1:0] k, input logic [63:0] p);
    @(negedge clk);
    req_vaddr = va; req_priv = pr; st_kx = kx; st_sx = sx; st_ux = ux;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, k, p);
  endtask

  task automatic test_reset;
    n_run++;
    if (res_valid !== 1'b0 || res_kind !== 2'd0 || res_paddr !== 64'd0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%b kind=%0d pa=%h, want 0 0 0", res_valid, res_kind, res_paddr);
    end
  endtask

  task automatic test_timing;
    ask(64'h10, 2'd0, 1, 1, 1, "R1 pulse", CMP, 64'h10);
    @(negedge clk);
    n_run++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: got v=%b want 0", res_valid);
    end
    @(negedge clk);
    req_vaddr = 64'h20; req_valid = 1'b1;
    @(negedge clk);
    chk("R1 back-to-back first", CMP, 64'h20);
    req_vaddr = 64'h30;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 back-to-back second", CMP, 64'h30);
  endtask

  task automatic test_compat;
    ask(64'h0000_0000_0000_1234, 2'd2, 0, 0, 0, "R2 low", CMP, 64'h1234);
    ask(64'h0000_0000_7FFF_FFFF, 2'd2, 0, 0, 0, "R2 low edge", CMP, 64'h7FFF_FFFF);
    ask(64'hFFFF_FFFF_8000_0010, 2'd2, 0, 0, 0, "R2 high", CMP, 64'hFFFF_FFFF_8000_0010);
  endtask

  task automatic test_xuser;
    ask(64'h0000_0000_8000_0000, 2'd2, 0, 0, 1, "R3 first mapped", TLB, 0);
    ask(64'h0000_0000_8000_0000, 2'd0, 1, 1, 0, "R3 ux clear", ERR, 0);
    ask(64'h0000_00FF_FFFF_FFFF, 2'd2, 0, 0, 1, "R3 at limit", TLB, 0);
    ask(64'h0000_0100_0000_0000, 2'd2, 0, 0, 1, "R3 past limit", ERR, 0);
  endtask

  task automatic test_xsuper;
    ask(64'h4000_0000_0000_1000, 2'd1, 0, 1, 0, "R4 supervisor", TLB, 0);
    ask(64'h4000_0000_0000_1000, 2'd3, 0, 1, 0, "R4 kernel err-level", TLB, 0);
    ask(64'h4000_0000_0000_1000, 2'd2, 1, 1, 1, "R4 user", ERR, 0);
    ask(64'h4000_0000_0000_1000, 2'd0, 1, 0, 1, "R4 sx clear", ERR, 0);
    ask(64'h4000_0100_0000_0000, 2'd0, 1, 1, 1, "R4 past limit", ERR, 0);
  endtask

  task automatic test_xkern;
    ask(64'hC000_0000_0000_0000, 2'd0, 1, 0, 0, "R10 kernel", TLB, 0);
    ask(64'hC000_0000_0000_0000, 2'd1, 1, 1, 1, "R10 supervisor", ERR, 0);
    ask(64'hC000_0000_0000_0000, 2'd0, 0, 1, 1, "R10 kx clear", ERR, 0);
    ask(64'hC000_0100_0000_0000, 2'd0, 1, 1, 1, "R10 past limit", ERR, 0);
  endtask

  task automatic test_window;
    win_slice_en = 8'h00; win_alt_mode = 3'd3;
    ask(64'h8000_0010_0000_0000, 2'd0, 1, 1, 1, "R5 beyond pa mask", ERR, 0);
    ask(64'h9000_0000_1234_5678, 2'd0, 1, 0, 0, "R9 R8 kernel mode0 direct", DIR, 64'h1234_5678);
    ask(64'h9000_0000_1234_5678, 2'd0, 0, 1, 1, "R7 mode0 kx clear", ERR, 0);
    ask(64'h9000_0000_1234_5678, 2'd2, 1, 1, 1, "R8 user mode0", ERR, 0);
    win_slice_en = 8'h01;
    ask(64'h9000_0000_1234_5678, 2'd0, 1, 0, 0, "R6 other slice enabled", DIR, 64'h1234_5678);
    win_slice_en = 8'h04;
    ask(64'h9000_0000_1234_5678, 2'd0, 0, 0, 1, "R6 R8 own slice mode3 kernel", TLB, 0);
    win_slice_en = 8'h80; win_alt_mode = 3'd7;
    ask(64'hB800_000A_BCDE_F000, 2'd2, 0, 0, 1, "R9 user mode7 direct", DIR, 64'hA_BCDE_F000);
    ask(64'hB800_000A_BCDE_F000, 2'd2, 1, 1, 0, "R7 mode7 ux clear", ERR, 0);
    win_alt_mode = 3'd5;
    ask(64'hB800_000A_BCDE_F000, 2'd1, 0, 1, 0, "R8 supervisor mode5 direct", DIR, 64'hA_BCDE_F000);
    ask(64'hB800_000A_BCDE_F000, 2'd1, 1, 0, 1, "R7 mode5 sx clear", ERR, 0);
    ask(64'hB800_000A_BCDE_F000, 2'd2, 0, 1, 0, "R8 user mode5", ERR, 0);
    win_alt_mode = 3'd4;
    ask(64'hB800_000A_BCDE_F000, 2'd2, 0, 0, 1, "R8 user mode4", TLB, 0);
    win_alt_mode = 3'd2;
    ask(64'hB800_000A_BCDE_F000, 2'd1, 0, 1, 0, "R8 supervisor mode2", TLB, 0);
    win_alt_mode = 3'd1;
    ask(64'hB800_000A_BCDE_F000, 2'd1, 1, 1, 1, "R8 supervisor mode1", ERR, 0);
    win_alt_mode = 3'd6;
    ask(64'hB800_000A_BCDE_F000, 2'd0, 1, 0, 0, "R8 R11 kernel mode6 direct", DIR, 64'hA_BCDE_F000);
    win_slice_en = 8'h00;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_timing();
    test_compat();
    test_xuser();
    test_xsuper();
    test_xkern();
    test_window();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule